// File: doc/BRIEF.md
# Oscillator Frequency-Lock Calibrator

This block trims a digitally controlled oscillator until it runs at a chosen whole multiple of a slow reference clock. The calibrator lives entirely in the oscillator's own clock domain. A free-running 16-bit counter advances on every oscillator cycle. Each rising edge of the reference clock, after synchronization, captures that counter. The capture minus the previous capture is the number of oscillator cycles in one reference period. With a 4096 Hz reference, a target of 256 cycles, for example, calls for 1 048 576 Hz.

Each measurement is compared with the programmed target, and the control outputs move one step per reference period. An 8-bit fine trim word is the low part of a carry chain. When it wraps, it carries into or borrows from a 3-bit range word. The range word clamps at 0 and at 7 instead of wrapping. Calibration stops only on an exact match. The counter and capture path then halt, `done` rises and both words hold their values. A `start` pulse begins a new run from the current trim position.

Top module: `fll_tuner`

## Requirements
- R1: While reset is held and directly after it, `fine_word` is 0x80, `range_sel` is 3 and `done` is 0. The trim words keep these values until the first `start`.
- R2: The measured count is the number of oscillator cycles between two consecutive synchronized reference rising edges, taken modulo 2^16. When `done` rises, that count equals `target_cnt`.
- R3: A measured count above `target_cnt` lowers `fine_word` by one. A step from 0x00 to 0xFF also lowers `range_sel` by one, and `range_sel` changes at no other time.
- R4: A measured count below `target_cnt` raises `fine_word` by one. A step from 0xFF to 0x00 also raises `range_sel` by one, and `range_sel` changes at no other time.
- R5: When `range_sel` is 0 and `fine_word` borrows from 0x00 to 0xFF, `range_sel` stays 0.
- R6: When `range_sel` is 7 and `fine_word` carries from 0xFF to 0x00, `range_sel` stays 7.
- R7: An exact match sets `done` to 1. While `done` is 1 and no `start` arrives, `fine_word` and `range_sel` do not change, whatever the reference does.
- R8: A `start` pulse clears `done` on the next cycle. It also zeroes the counter and the previous capture, so the first measurement of a run is taken from zero, and it begins a new run. The first adjustment of a run waits for a fresh reference edge.
- R9: At most one adjustment of the trim words happens per reference period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| osc_clk | input | 1 | Oscillator clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a calibration run |
| target_cnt | input | 16 | Required oscillator cycles per reference period |
| ref_clk | input | 1 | Slow reference clock, asynchronous to osc_clk |
| fine_word | output | 8 | Fine trim word to the oscillator |
| range_sel | output | 3 | Coarse range select to the oscillator |
| done | output | 1 | High once the measured count equals the target |

## Verification
The hardest states to reach are the two clamped ends of the carry chain. Reaching them takes a full fine-word wrap while the range word already sits at 0 or 7, which means hundreds of consecutive one-way steps. The bench models the oscillator so that the reference period in oscillator cycles is a monotonic function of the two trim words. It then programs targets below the slowest and above the fastest reachable count. This drives the loop into each rail and holds it there long enough to see the fine word wrap with the range word pinned. A monitor checks every trim change against the single-step carry and borrow rules along the way.

// File: rtl/fll_pkg.sv
package fll_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_LOCK
    } fll_state_e;

endpackage

// File: rtl/fll_ref_sync.sv
module fll_ref_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_in,
    output logic stb
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
        logic              last;
    } sync_t;

    sync_t cur_q, nxt_d;

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.sh   = {cur_q.sh[STAGES-2:0], ref_in};
        nxt_d.last = cur_q.sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    // one-cycle pulse on the rising edge of the synchronized reference
    assign stb = cur_q.sh[STAGES-1] & ~cur_q.last;

endmodule

// File: rtl/fll_capture.sv
module fll_capture #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    input  logic             stb,
    output logic             meas_vld,
    output logic [CNT_W-1:0] meas_cnt
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic [CNT_W-1:0] prev;
        logic             vld;
    } cap_t;

    cap_t cur_q, nxt_d;

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.vld = 1'b0;
        if (run) begin
            nxt_d.cnt = cur_q.cnt + 1'b1;
            if (stb) begin
                nxt_d.cap = cur_q.cnt;
                nxt_d.vld = 1'b1;
            end
        end
        if (cur_q.vld) nxt_d.prev = cur_q.cap;
        if (clear) begin
            nxt_d.cnt  = '0;
            nxt_d.prev = '0;
            nxt_d.vld  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign meas_vld = cur_q.vld;
    assign meas_cnt = cur_q.cap - cur_q.prev;  // modulo 2^CNT_W

endmodule

// File: rtl/fll_step.sv
module fll_step #(
    parameter int FINE_W  = 8,
    parameter int RANGE_W = 3
) (
    input  logic [FINE_W-1:0]  fine_in,
    input  logic [RANGE_W-1:0] range_in,
    output logic [FINE_W-1:0]  up_fine,
    output logic [RANGE_W-1:0] up_range,
    output logic [FINE_W-1:0]  dn_fine,
    output logic [RANGE_W-1:0] dn_range
);
    localparam logic [FINE_W-1:0]  FINE_TOP  = {FINE_W{1'b1}};
    localparam logic [RANGE_W-1:0] RANGE_TOP = {RANGE_W{1'b1}};

    always_comb begin
        up_fine  = fine_in + 1'b1;
        up_range = range_in;
        if (fine_in == FINE_TOP && range_in != RANGE_TOP)
            up_range = range_in + 1'b1;

        dn_fine  = fine_in - 1'b1;
        dn_range = range_in;
        if (fine_in == '0 && range_in != '0)
            dn_range = range_in - 1'b1;
    end

endmodule

// File: rtl/fll_tuner.sv
module fll_tuner
    import fll_pkg::*;
#(
    parameter int             CNT_W       = 16,
    parameter int             FINE_W      = 8,
    parameter int             RANGE_W     = 3,
    parameter int             SYNC_STAGES = 2,
    parameter logic [7:0]     FINE_INIT   = 8'h80,
    parameter logic [2:0]     RANGE_INIT  = 3'd3
) (
    input  logic               osc_clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   target_cnt,
    input  logic               ref_clk,
    output logic [FINE_W-1:0]  fine_word,
    output logic [RANGE_W-1:0] range_sel,
    output logic               done
);
    typedef struct packed {
        fll_state_e         st;
        logic [FINE_W-1:0]  fine;
        logic [RANGE_W-1:0] range;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        st:    ST_IDLE,
        fine:  FINE_W'(FINE_INIT),
        range: RANGE_W'(RANGE_INIT)
    };

    ctl_t cur_q, nxt_d;

    logic               ref_stb;
    logic               meas_vld;
    logic [CNT_W-1:0]   meas_cnt;
    logic [FINE_W-1:0]  up_fine, dn_fine;
    logic [RANGE_W-1:0] up_range, dn_range;

    fll_ref_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (osc_clk),
        .rst_n  (rst_n),
        .ref_in (ref_clk),
        .stb    (ref_stb)
    );

    fll_capture #(.CNT_W(CNT_W)) u_cap (
        .clk      (osc_clk),
        .rst_n    (rst_n),
        .clear    (start),
        .run      (cur_q.st == ST_RUN),
        .stb      (ref_stb),
        .meas_vld (meas_vld),
        .meas_cnt (meas_cnt)
    );

    fll_step #(.FINE_W(FINE_W), .RANGE_W(RANGE_W)) u_step (
        .fine_in  (cur_q.fine),
        .range_in (cur_q.range),
        .up_fine  (up_fine),
        .up_range (up_range),
        .dn_fine  (dn_fine),
        .dn_range (dn_range)
    );

    always_comb begin
        nxt_d = cur_q;
        if (start) begin
            nxt_d.st = ST_RUN;
        end else if (cur_q.st == ST_RUN && meas_vld) begin
            if (meas_cnt == target_cnt) begin
                nxt_d.st = ST_LOCK;
            end else if (meas_cnt > target_cnt) begin
                nxt_d.fine  = dn_fine;
                nxt_d.range = dn_range;
            end else begin
                nxt_d.fine  = up_fine;
                nxt_d.range = up_range;
            end
        end
    end

    always_ff @(posedge osc_clk or negedge rst_n) begin
        if (!rst_n) cur_q <= CTL_RESET;
        else        cur_q <= nxt_d;
    end

    assign fine_word = cur_q.fine;
    assign range_sel = cur_q.range;
    assign done      = (cur_q.st == ST_LOCK);

endmodule

// File: rtl/fll_tuner_chk.sv
module fll_tuner_chk #(
    parameter int FINE_W  = 8,
    parameter int RANGE_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               stb,
    input logic               done,
    input logic [FINE_W-1:0]  fine,
    input logic [RANGE_W-1:0] range_sel
);
    localparam logic [FINE_W-1:0]  F_TOP = {FINE_W{1'b1}};
    localparam logic [RANGE_W-1:0] R_TOP = {RANGE_W{1'b1}};

    logic [FINE_W-1:0]  fine_prev_q;
    logic [RANGE_W-1:0] range_prev_q;
    logic               seen_q;
    logic               chg;

    always_ff @(posedge clk) begin
        fine_prev_q  <= fine;
        range_prev_q <= range_sel;
    end

    assign chg = (fine != fine_prev_q) || (range_sel != range_prev_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   seen_q <= 1'b0;
        else if (stb) seen_q <= 1'b0;
        else if (chg) seen_q <= 1'b1;
    end

    p_borrow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fine) == '0 && fine == F_TOP) |->
            (range_sel == RANGE_W'($past(range_sel) - 1'b1) || ($past(range_sel) == '0 && range_sel == '0)));

    p_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(fine) == F_TOP && fine == '0) |->
            (range_sel == RANGE_W'($past(range_sel) + 1'b1) || ($past(range_sel) == R_TOP && range_sel == R_TOP)));

    p_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> ($stable(fine) && $stable(range_sel)));

    p_start_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !done);

    p_one_adj_r9: assert property (@(posedge clk) disable iff (!rst_n)
        chg |-> !seen_q);

endmodule

bind fll_tuner fll_tuner_chk #(.FINE_W(FINE_W), .RANGE_W(RANGE_W)) u_chk (
    .clk       (osc_clk),
    .rst_n     (rst_n),
    .start     (start),
    .stb       (ref_stb),
    .done      (done),
    .fine      (fine_word),
    .range_sel (range_sel)
);

// File: tb/tb_fll_tuner.sv
module tb_fll_tuner;

    localparam int NVEC = 3;
    localparam int unsigned TGT   [NVEC] = '{36, 40, 33};
    localparam int unsigned EXP_R [NVEC] = '{3, 4, 3};
    localparam string       TAG   [NVEC] = '{"R2", "R4", "R3"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] target_cnt = 16'd0;
    logic        ref_clk = 1'b0;
    logic [7:0]  fine_word;
    logic [2:0]  range_sel;
    logic        done;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int bad_moves = 0, multi_adj = 0, frozen_bad = 0;
    int sat_hi = 0, sat_lo = 0;

    always #5 clk = ~clk;

    fll_tuner dut (
        .osc_clk    (clk),
        .rst_n      (rst_n),
        .start      (start),
        .target_cnt (target_cnt),
        .ref_clk    (ref_clk),
        .fine_word  (fine_word),
        .range_sel  (range_sel),
        .done       (done)
    );

    // oscillator model: reference period in oscillator cycles, monotonic in trim
    function automatic int period_of(input logic [7:0] f, input logic [2:0] r);
        return 8 + 8 * int'(r) + int'(f) / 32;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // reference generator: rise-to-rise spacing follows the current trim words
    initial begin
        int n;
        @(negedge clk);
        forever begin
            ref_clk = 1'b1;
            repeat (6) @(negedge clk);
            ref_clk = 1'b0;
            n = period_of(fine_word, range_sel);
            repeat (n - 6) @(negedge clk);
        end
    end

    // monitor of every trim-word change (R3, R4, R5, R6, R7, R9)
    initial begin
        logic [7:0] pf;
        logic [2:0] pr;
        logic       pd, pref;
        int         per_chg;
        pf = 8'h80; pr = 3'd3; pd = 1'b0; pref = 1'b0; per_chg = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) begin
                pf = fine_word; pr = range_sel; pd = 1'b0; per_chg = 0;
            end else begin
                if (ref_clk && !pref) per_chg = 0;
                if (fine_word != pf || range_sel != pr) begin
                    per_chg++;
                    if (per_chg > 1) multi_adj++;
                    if (pd && done) frozen_bad++;
                    if (fine_word == 8'(pf + 1'b1)) begin
                        if (pf == 8'hFF) begin
                            if (pr == 3'd7) begin
                                if (range_sel == 3'd7) sat_hi++; else bad_moves++;
                            end else if (range_sel != 3'(pr + 1'b1)) bad_moves++;
                        end else if (range_sel != pr) bad_moves++;
                    end else if (fine_word == 8'(pf - 1'b1)) begin
                        if (pf == 8'h00) begin
                            if (pr == 3'd0) begin
                                if (range_sel == 3'd0) sat_lo++; else bad_moves++;
                            end else if (range_sel != 3'(pr - 1'b1)) bad_moves++;
                        end else if (range_sel != pr) bad_moves++;
                    end else begin
                        bad_moves++;
                    end
                end
                pf = fine_word; pr = range_sel; pd = done;
            end
            pref = ref_clk;
        end
    end

    initial begin
        #1_800_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    task automatic pulse_start(input int unsigned tgt);
        @(negedge clk);
        target_cnt = 16'(tgt);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [7:0] hf;
        logic [2:0] hr;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(fine_word == 8'h80, "R1 fine", fine_word, 8'h80);
        chk(range_sel == 3'd3, "R1 range", range_sel, 3);
        chk(done == 1'b0, "R1 done", done, 0);

        // no start yet: trim must stay put
        repeat (200) @(negedge clk);
        chk(fine_word == 8'h80, "R1 idle fine", fine_word, 8'h80);
        chk(range_sel == 3'd3, "R1 idle range", range_sel, 3);

        for (int i = 0; i < NVEC; i++) begin
            pulse_start(TGT[i]);
            chk(done == 1'b0, "R8 start clears done", done, 0);
            for (int c = 0; c < 40000 && !done; c++) @(negedge clk);
            chk(done == 1'b1, "R7 lock reached", done, 1);
            chk(period_of(fine_word, range_sel) == int'(TGT[i]), "R2 count at lock",
                period_of(fine_word, range_sel), TGT[i]);
            chk(range_sel == 3'(EXP_R[i]), TAG[i], range_sel, EXP_R[i]);
            hf = fine_word; hr = range_sel;
            repeat (300) @(negedge clk);
            chk(fine_word == hf && range_sel == hr, "R7 frozen", fine_word, hf);
            chk(done == 1'b1, "R7 done held", done, 1);
        end

        // upper rail: unreachable fast target
        do_reset();
        pulse_start(80);
        for (int c = 0; c < 100000 && sat_hi == 0; c++) @(negedge clk);
        chk(sat_hi > 0, "R6 carry at top", sat_hi, 1);
        chk(range_sel == 3'd7, "R6 range pinned", range_sel, 7);
        chk(done == 1'b0, "R6 no lock", done, 0);

        // lower rail: unreachable slow target
        do_reset();
        pulse_start(4);
        for (int c = 0; c < 50000 && sat_lo == 0; c++) @(negedge clk);
        chk(sat_lo > 0, "R5 borrow at bottom", sat_lo, 1);
        chk(range_sel == 3'd0, "R5 range pinned", range_sel, 0);
        chk(done == 1'b0, "R5 no lock", done, 0);

        chk(bad_moves == 0, "R3/R4 step rule (R3)", bad_moves, 0);
        chk(multi_adj == 0, "R9 one step per period", multi_adj, 0);
        chk(frozen_bad == 0, "R7 change while done", frozen_bad, 0);

        finish_run();
    end

endmodule